// File: doc/BRIEF.md
# Dual-Port Address-Collision Arbiter

This block watches two independent request ports, left and right, that share one memory array, and it decides what happens when both point at the same word at the same time. Each port brings an address, an enable and a write strobe. When both ports are enabled on equal addresses, one port keeps the location and the other is flagged busy. The busy port's write strobe toward the array is suppressed. Its read traffic is not touched, because the block only gates the write strobe.

The block is a clocked model of an asynchronous collision arbiter. A port "arrives" in a cycle when its enable has just risen or its address differs from the previous cycle. An arriving port loses to a port that was already settled there. If both arrive together, the left port wins. The winner holds the location until the collision ends or the winner itself moves.

A static strap selects the role of the part. As arbiter (master), it generates busy flags locally and drives them out. As follower (slave), it generates no busy flags. Instead it takes busy indications from an external arbiter and uses them only to block local writes. This lets several parts share one arbitration decision when they are placed side by side to widen the data bus.

Top module: `dpa_collision_arbiter`

## Requirements
- R1: In master mode (`master_mode`=1), when both enables are high and the addresses are equal, exactly one busy output goes high one clock edge after that cycle. Busy outputs are active high.
- R2: A busy output returns low one clock edge after a cycle in which the addresses differ or either enable is low.
- R3: A port arrives in a cycle when its enable rose or its address differs from the previous cycle. When a collision begins, an arriving port loses to a port that did not arrive: the arriving port gets busy. This covers both address-change collisions and enable-rise collisions.
- R4: If both ports arrive in the same cycle on a colliding address, the left port wins and `r_busy_out` goes high.
- R5: A collision created only by an enable rising while the other port sits at that address asserts busy on the port whose enable rose.
- R6: The winner keeps the location while it stays enabled at an unchanged address. If the loser drops its enable and later re-enables, it is still the loser. If the winner moves away and returns, it becomes the arriving port and loses.
- R7: The two busy outputs are never high together.
- R8: In master mode, `x_wr_gated` = `x_en` AND `x_wr` AND NOT (this port loses the arbitration). The loss is decided combinationally within the colliding cycle itself, so a write in the first colliding cycle is already blocked.
- R9: After synchronous reset (`rst`=1), both busy outputs are low.
- R10: In slave mode (`master_mode`=0), both busy outputs stay low, and `x_wr_gated` = `x_en` AND `x_wr` AND NOT `x_busy_in` (combinational). In master mode, the busy inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | Strap: 1 = generate busy, 0 = follow external busy |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write strobe |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write strobe |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in | input | 1 | External busy for left port (slave mode) |
| r_busy_in | input | 1 | External busy for right port (slave mode) |
| l_busy_out | output | 1 | Left port busy (master mode, registered) |
| r_busy_out | output | 1 | Right port busy (master mode, registered) |
| l_wr_gated | output | 1 | Left write strobe toward the array |
| r_wr_gated | output | 1 | Right write strobe toward the array |

## Verification
The bench targets the ordering cases:
- A same-cycle arrival must go to the left port. A design that broke ties toward the late or the right port would flag the wrong side.
- An enable-rise collision must flag the port that just rose. A design that compared addresses only, without enables, would miss this case or flag the settled port.
- A loser that drops and re-raises its enable must not steal the location. A winner that leaves and returns must lose it. A design that re-arbitrated by fixed priority would fail one of these two cases.

It also checks that the write strobe is blocked in the very first colliding cycle, before the registered busy appears. It checks that slave mode ignores local arbitration and obeys only the busy inputs.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    // Pick the owner of a freshly detected collision from arrival flags.
    // A settled port beats an arriving one; a dead heat goes left.
    function automatic owner_e pick_owner(input logic l_arrive, input logic r_arrive);
        if (l_arrive && !r_arrive) return OWN_RIGHT;
        return OWN_LEFT;
    endfunction

endpackage

// File: rtl/dpa_arrival.sv
module dpa_arrival #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              arrive
);
    logic              en_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            en_q   <= en;
            addr_q <= addr;
        end
    end

    assign arrive = en && (!en_q || (addr != addr_q));

endmodule

// File: rtl/dpa_owner.sv
module dpa_owner
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_arrive,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_arrive,
    output owner_e            owner_q,
    output owner_e            owner_d
);
    logic collide;
    logic keep;

    assign collide = master_mode && l_en && r_en && (l_addr == r_addr);

    always_comb begin
        unique case (owner_q)
            OWN_LEFT:  keep = !l_arrive;
            OWN_RIGHT: keep = !r_arrive;
            default:   keep = 1'b0;
        endcase
    end

    always_comb begin
        if (!collide)  owner_d = OWN_NONE;
        else if (keep) owner_d = owner_q;
        else           owner_d = pick_owner(l_arrive, r_arrive);
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= OWN_NONE;
        else     owner_q <= owner_d;
    end

    // R2: no collision this cycle means no owner on the next
    p_release_r2: assert property (@(posedge clk) disable iff (rst)
        !(l_en && r_en && (l_addr == r_addr)) |=> (owner_q == OWN_NONE));

    // R6: a settled winner keeps the location while the collision lasts
    p_hold_left_r6: assert property (@(posedge clk) disable iff (rst)
        (owner_q == OWN_LEFT && !l_arrive && collide) |=> (owner_q == OWN_LEFT));
    p_hold_right_r6: assert property (@(posedge clk) disable iff (rst)
        (owner_q == OWN_RIGHT && !r_arrive && collide) |=> (owner_q == OWN_RIGHT));

    // R10: slave mode never records an owner
    p_slave_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !master_mode |=> (owner_q == OWN_NONE));

endmodule

// File: rtl/dpa_collision_arbiter.sv
module dpa_collision_arbiter
    import dpa_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              master_mode,
    input  logic              l_en,
    input  logic              l_wr,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic              r_wr,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              l_busy_in,
    input  logic              r_busy_in,
    output logic              l_busy_out,
    output logic              r_busy_out,
    output logic              l_wr_gated,
    output logic              r_wr_gated
);
    localparam int NPORT = 2;
    localparam int LEFT  = 0;
    localparam int RIGHT = 1;

    logic [NPORT-1:0]  en_v, wr_v, bin_v, arrive_v, lose_v, inhibit_v, wr_out_v;
    logic [ADDR_W-1:0] addr_v [NPORT];
    owner_e            owner_q, owner_d;

    assign en_v  = {r_en, l_en};
    assign wr_v  = {r_wr, l_wr};
    assign bin_v = {r_busy_in, l_busy_in};
    assign addr_v[LEFT]  = l_addr;
    assign addr_v[RIGHT] = r_addr;

    assign lose_v[LEFT]  = (owner_d == OWN_RIGHT);
    assign lose_v[RIGHT] = (owner_d == OWN_LEFT);

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dpa_arrival #(.ADDR_W(ADDR_W)) u_arrive (
            .clk    (clk),
            .rst    (rst),
            .en     (en_v[p]),
            .addr   (addr_v[p]),
            .arrive (arrive_v[p])
        );
        assign inhibit_v[p] = master_mode ? lose_v[p] : bin_v[p];
        assign wr_out_v[p]  = en_v[p] && wr_v[p] && !inhibit_v[p];
    end

    dpa_owner #(.ADDR_W(ADDR_W)) u_owner (
        .clk         (clk),
        .rst         (rst),
        .master_mode (master_mode),
        .l_en        (l_en),
        .l_addr      (l_addr),
        .l_arrive    (arrive_v[LEFT]),
        .r_en        (r_en),
        .r_addr      (r_addr),
        .r_arrive    (arrive_v[RIGHT]),
        .owner_q     (owner_q),
        .owner_d     (owner_d)
    );

    assign l_busy_out = master_mode && (owner_q == OWN_RIGHT);
    assign r_busy_out = master_mode && (owner_q == OWN_LEFT);
    assign l_wr_gated = wr_out_v[LEFT];
    assign r_wr_gated = wr_out_v[RIGHT];

    // R7: busy is mutually exclusive
    p_busy_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(l_busy_out && r_busy_out));

    // R1: busy only follows a cycle with both enabled on one address
    p_busy_cause_r1: assert property (@(posedge clk) disable iff (rst)
        (l_busy_out || r_busy_out) |-> $past(l_en && r_en && (l_addr == r_addr)));

    // R8: a port flagged busy while still colliding cannot write
    p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        (master_mode && l_busy_out && l_en && r_en && (l_addr == r_addr)
         && $stable(r_addr) && $stable(r_en)) |-> !l_wr_gated);

endmodule

// File: tb/dpa_collision_arbiter_test.sv
module dpa_collision_arbiter_test;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst, master_mode;
    logic l_en, l_wr, r_en, r_wr, l_busy_in, r_busy_in;
    logic [AW-1:0] l_addr, r_addr;
    logic l_busy_out, r_busy_out, l_wr_gated, r_wr_gated;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dpa_collision_arbiter #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .master_mode(master_mode),
        .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr),
        .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr),
        .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
        .l_busy_out(l_busy_out), .r_busy_out(r_busy_out),
        .l_wr_gated(l_wr_gated), .r_wr_gated(r_wr_gated)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        l_en = 0; r_en = 0; l_wr = 0; r_wr = 0;
        l_busy_in = 0; r_busy_in = 0;
        tick(); tick();
    endtask

    task automatic t_reset();
        rst = 1; master_mode = 1;
        l_en = 1; r_en = 1; l_addr = 7; r_addr = 7; l_wr = 0; r_wr = 0;
        l_busy_in = 0; r_busy_in = 0;
        tick(); tick();
        chk("R9 l_busy after reset", l_busy_out, 1'b0);
        chk("R9 r_busy after reset", r_busy_out, 1'b0);
        rst = 0;
        idle();
    endtask

    task automatic t_tie();
        l_addr = 5; r_addr = 5; l_en = 1; r_en = 1; l_wr = 1; r_wr = 1;
        #1;
        chk("R8 winner write passes", l_wr_gated, 1'b1);
        chk("R8 loser write blocked same cycle", r_wr_gated, 1'b0);
        tick();
        chk("R4 tie right busy", r_busy_out, 1'b1);
        chk("R1 tie left not busy", l_busy_out, 1'b0);
        tick();
        chk("R6 held right busy", r_busy_out, 1'b1);
        chk("R7 not both busy", l_busy_out && r_busy_out, 1'b0);
        r_addr = 6;
        #1;
        chk("R8 write after move", r_wr_gated, 1'b1);
        tick();
        chk("R2 release on mismatch", r_busy_out, 1'b0);
        idle();
    endtask

    task automatic t_enable_rise();
        r_addr = 9; r_en = 1; r_wr = 1;
        tick();
        l_addr = 9; l_en = 1; l_wr = 1;
        #1;
        chk("R5 late left write blocked", l_wr_gated, 1'b0);
        chk("R5 settled right write passes", r_wr_gated, 1'b1);
        tick();
        chk("R5 enable-rise left busy", l_busy_out, 1'b1);
        chk("R3 settled right not busy", r_busy_out, 1'b0);
        l_en = 0;
        tick();
        chk("R2 release on enable drop", l_busy_out, 1'b0);
        l_en = 1;
        tick();
        chk("R6 loser re-enable still busy", l_busy_out, 1'b1);
        idle();
    endtask

    task automatic t_addr_move();
        r_addr = 9; r_en = 1; l_addr = 3; l_en = 1;
        tick();
        l_addr = 9;
        tick();
        chk("R3 address-change left busy", l_busy_out, 1'b1);
        chk("R3 right keeps", r_busy_out, 1'b0);
        r_addr = 4;
        tick();
        chk("R2 release winner moved", l_busy_out, 1'b0);
        r_addr = 9;
        tick();
        chk("R6 returning winner loses", r_busy_out, 1'b1);
        chk("R6 settled left now wins", l_busy_out, 1'b0);
        idle();
    endtask

    task automatic t_master_ignores_in();
        l_addr = 1; r_addr = 2; l_en = 1; r_en = 1; l_wr = 1; r_wr = 1;
        l_busy_in = 1; r_busy_in = 1;
        #1;
        chk("R10 master ignores l_busy_in", l_wr_gated, 1'b1);
        chk("R10 master ignores r_busy_in", r_wr_gated, 1'b1);
        idle();
    endtask

    task automatic t_slave();
        master_mode = 0;
        l_addr = 8; r_addr = 8; l_en = 1; r_en = 1; l_wr = 1; r_wr = 1;
        tick(); tick();
        chk("R10 slave l_busy low", l_busy_out, 1'b0);
        chk("R10 slave r_busy low", r_busy_out, 1'b0);
        chk("R10 slave no local block", r_wr_gated, 1'b1);
        l_busy_in = 1;
        #1;
        chk("R10 slave busy_in blocks left", l_wr_gated, 1'b0);
        chk("R10 slave right unaffected", r_wr_gated, 1'b1);
        l_busy_in = 0; r_busy_in = 1;
        #1;
        chk("R10 slave left released", l_wr_gated, 1'b1);
        chk("R10 slave busy_in blocks right", r_wr_gated, 1'b0);
        idle();
        master_mode = 1;
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_tie();
        t_enable_rise();
        t_addr_move();
        t_master_ignores_in();
        t_slave();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule